// File: doc/BRIEF.md
# Extender-Shaped Mode-Select ALU

This block is a purely combinational integer ALU of parameterized width, 16 bits by default. It has eight operations. A mode bit picks the family, arithmetic or logic, and a two-bit select picks the operation within that family. The ALU has only one adder, a ripple chain that builds each bit from majority functions, and every result comes out of that adder.

Two small shaping stages sit in front of the adder, so no multiplexer is needed after it. In arithmetic mode, the arithmetic shaper rewrites the second operand and the carry-in so that the same adder can add, subtract, increment or decrement. In logic mode, the logic shaper computes the bitwise function and places it on the first adder input. It also holds the second input and the carry-in at zero. Every majority carry is then zero, and each adder bit passes its first input straight through to the result.

The block is used as a datapath element: the operands and controls go in, and the result and carry-out are valid in the same cycle.

Top module: `ext_alu`

## Requirements
- R1: With mode_i=0 and sel_i=2'b00, {cout_o,res_o} equals the unsigned sum a_in + b_in, with the carry in bit WIDTH.
- R2: With mode_i=0 and sel_i=2'b01, res_o equals a_in - b_in modulo 2^WIDTH. cout_o is 1 exactly when a_in >= b_in, meaning no borrow.
- R3: With mode_i=0 and sel_i=2'b10, res_o equals a_in + 1 and b_in has no effect. cout_o is 1 exactly when a_in is all ones.
- R4: With mode_i=0 and sel_i=2'b11, res_o equals a_in - 1 and b_in has no effect. cout_o is 1 exactly when a_in is nonzero.
- R5: With mode_i=1 and sel_i=2'b00, res_o equals a_in AND b_in.
- R6: With mode_i=1 and sel_i=2'b01, res_o equals a_in OR b_in.
- R7: With mode_i=1 and sel_i=2'b10, res_o equals a_in XOR b_in.
- R8: With mode_i=1 and sel_i=2'b11, res_o equals NOT a_in and b_in has no effect.
- R9: In logic mode (mode_i=1), cout_o is 0 and every internal ripple carry is 0 for all operands. The adder's second input is zero, and the result is the logic shaper's output unchanged.
- R10: The block has no state. A change on any input appears at res_o and cout_o without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| mode_i | input | 1 | 0 = arithmetic family, 1 = logic family |
| sel_i | input | 2 | Operation select within the family; bit 1 is the upper select |
| res_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry-out of the adder; 0 in logic mode |

## Verification
The bound checker watches the internal ripple carries and the adder's inputs whenever the inputs change. It checks that logic mode keeps every carry and the second adder input at zero, and that the result in logic mode equals the shaper output. In arithmetic mode it checks that the majority chain produces the true sum of its shaped inputs, and it also checks the subtract and complement results against the ports directly. Only the bench scenarios can show that each select code is decoded to the intended operation, since that needs an independent reference model. The same holds for the boundary carries of increment and decrement at all-ones and zero, for operand B having no effect on the unary operations, and for the outputs settling without a clock.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;

  // Select codes within each family (sel_i value)
  localparam logic [1:0] ASEL_ADD = 2'b00;
  localparam logic [1:0] ASEL_SUB = 2'b01;
  localparam logic [1:0] ASEL_INC = 2'b10;
  localparam logic [1:0] ASEL_DEC = 2'b11;

  localparam logic [1:0] LSEL_AND = 2'b00;
  localparam logic [1:0] LSEL_OR  = 2'b01;
  localparam logic [1:0] LSEL_XOR = 2'b10;
  localparam logic [1:0] LSEL_NOT = 2'b11;

  typedef enum logic {FAM_ARITH = 1'b0, FAM_LOGIC = 1'b1} family_e;

  // Three-input majority: the only gate used by the adder
  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (q & r) | (r & p);
  endfunction

  // Per-bit second-operand shaping for arithmetic mode
  function automatic logic arith_y_bit(input logic [1:0] sel, input logic b);
    case (sel)
      ASEL_ADD: return b;
      ASEL_SUB: return ~b;
      ASEL_INC: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

  // Carry-in shaping for arithmetic mode
  function automatic logic arith_cin(input logic [1:0] sel);
    return (sel == ASEL_SUB) || (sel == ASEL_INC);
  endfunction

  // Per-bit logic function
  function automatic logic logic_bit(input logic [1:0] sel, input logic a, input logic b);
    case (sel)
      LSEL_AND: return a & b;
      LSEL_OR:  return a | b;
      LSEL_XOR: return a ^ b;
      default:  return ~a;
    endcase
  endfunction

endpackage

// File: rtl/ext_alu_arith_shaper.sv
module ext_alu_arith_shaper
  import ext_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             active_i,
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o,
  output logic             cin_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_o[i] = active_i & arith_y_bit(sel_i, b_i[i]);
  end

  assign cin_o = active_i & arith_cin(sel_i);

endmodule

// File: rtl/ext_alu_logic_shaper.sv
module ext_alu_logic_shaper
  import ext_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             active_i,
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] x_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // Arithmetic mode: operand A goes to the adder unchanged
    assign x_o[i] = active_i ? logic_bit(sel_i, a_i[i], b_i[i]) : a_i[i];
  end

endmodule

// File: rtl/ext_alu_maj_adder.sv
module ext_alu_maj_adder
  import ext_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             cin_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH:0]   carry_o
);

  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic nc_in;   // inverse of carry into this bit
    logic nc_out;  // inverse of carry out of this bit
    logic inner;
    assign c[i+1]   = maj3(x_i[i], y_i[i], c[i]);
    assign nc_in    = ~c[i];
    assign nc_out   = ~c[i+1];
    assign inner    = maj3(x_i[i], y_i[i], nc_in);
    assign sum_o[i] = maj3(inner, nc_out, c[i]);
  end

  assign carry_o = c;

endmodule

// File: rtl/ext_alu.sv
module ext_alu
  import ext_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             mode_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);

  family_e        fam;
  logic           arith_on;
  logic           logic_on;
  logic [WIDTH-1:0] adder_x;
  logic [WIDTH-1:0] adder_y;
  logic             adder_cin;
  logic [WIDTH:0]   carry_vec;
  logic [WIDTH-1:0] adder_sum;

  assign fam      = family_e'(mode_i);
  assign arith_on = (fam == FAM_ARITH);
  assign logic_on = (fam == FAM_LOGIC);

  ext_alu_arith_shaper #(.WIDTH(WIDTH)) u_ashp (
    .active_i (arith_on),
    .sel_i    (sel_i),
    .b_i      (b_in),
    .y_o      (adder_y),
    .cin_o    (adder_cin)
  );

  ext_alu_logic_shaper #(.WIDTH(WIDTH)) u_lshp (
    .active_i (logic_on),
    .sel_i    (sel_i),
    .a_i      (a_in),
    .b_i      (b_in),
    .x_o      (adder_x)
  );

  ext_alu_maj_adder #(.WIDTH(WIDTH)) u_add (
    .cin_i   (adder_cin),
    .x_i     (adder_x),
    .y_i     (adder_y),
    .sum_o   (adder_sum),
    .carry_o (carry_vec)
  );

  assign res_o  = adder_sum;
  assign cout_o = carry_vec[WIDTH];

endmodule

// File: rtl/ext_alu_chk.sv
module ext_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             mode_i,
  input logic [1:0]       sel_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] adder_x,
  input logic [WIDTH-1:0] adder_y,
  input logic             adder_cin,
  input logic [WIDTH:0]   carry_vec
);

  logic known;
  assign known = !$isunknown({a_in, b_in, mode_i, sel_i, res_o, cout_o,
                              adder_x, adder_y, adder_cin, carry_vec});

  always_comb begin
    if (known) begin
      // R9: logic mode keeps the whole ripple chain quiet
      if (mode_i)
        assert_logic_carries_zero_R9: assert (carry_vec == '0 && cout_o == 1'b0);
      if (mode_i)
        assert_logic_y_zero_R9: assert (adder_y == '0 && adder_cin == 1'b0);
      if (mode_i)
        assert_logic_passthru_R9: assert (res_o == adder_x);
      // R1: the majority chain computes the true sum of its shaped inputs
      if (!mode_i)
        assert_adder_sum_R1: assert ({cout_o, res_o} ==
          ({1'b0, adder_x} + {1'b0, adder_y} + {{WIDTH{1'b0}}, adder_cin}));
      // R2: subtract seen at the ports
      if (!mode_i && sel_i == 2'b01)
        assert_sub_ports_R2: assert ({cout_o, res_o} ==
          ({1'b0, a_in} + {1'b0, ~b_in} + {{WIDTH{1'b0}}, 1'b1}));
      // R8: complement seen at the ports
      if (mode_i && sel_i == 2'b11)
        assert_not_ports_R8: assert (res_o == ~a_in);
    end
  end

endmodule

bind ext_alu ext_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in      (a_in),
  .b_in      (b_in),
  .mode_i    (mode_i),
  .sel_i     (sel_i),
  .res_o     (res_o),
  .cout_o    (cout_o),
  .adder_x   (adder_x),
  .adder_y   (adder_y),
  .adder_cin (adder_cin),
  .carry_vec (carry_vec)
);

// File: tb/sim_ext_alu.sv
module sim_ext_alu;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic         mode, cout;
  logic [1:0]   sel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  ext_alu #(.WIDTH(W)) u0 (
    .a_in(a), .b_in(b), .mode_i(mode), .sel_i(sel),
    .res_o(res), .cout_o(cout)
  );

  // Fields: mode[51] sel[50:49] a[48:33] b[32:17] cout[16] res[15:0]
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h1234, 16'h4321, 1'b0, 16'h5555},
    {1'b0, 2'd0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},
    {1'b0, 2'd1, 16'h0005, 16'h0003, 1'b1, 16'h0002},
    {1'b0, 2'd1, 16'h0003, 16'h0005, 1'b0, 16'hFFFE},
    {1'b0, 2'd2, 16'hFFFF, 16'hABCD, 1'b1, 16'h0000},
    {1'b0, 2'd2, 16'h00FF, 16'h1111, 1'b0, 16'h0100},
    {1'b0, 2'd3, 16'h0000, 16'h5555, 1'b0, 16'hFFFF},
    {1'b0, 2'd3, 16'h8000, 16'h0000, 1'b1, 16'h7FFF},
    {1'b1, 2'd0, 16'hF0F0, 16'hFF00, 1'b0, 16'hF000},
    {1'b1, 2'd1, 16'hF0F0, 16'h0F0F, 1'b0, 16'hFFFF},
    {1'b1, 2'd2, 16'hAAAA, 16'hFFFF, 1'b0, 16'h5555},
    {1'b1, 2'd3, 16'h1234, 16'hFFFF, 1'b0, 16'hEDCB}
  };

  function automatic string tag(input logic m, input logic [1:0] s);
    case ({m, s})
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference, written from the requirements
  function automatic logic [W:0] model(input logic m, input logic [1:0] s,
                                       input logic [W-1:0] x, input logic [W-1:0] y);
    if (!m) begin
      case (s)
        2'd0: return {1'b0, x} + {1'b0, y};
        2'd1: return {(x >= y), W'(x - y)};
        2'd2: return {(x == '1), W'(x + 1'b1)};
        default: return {(x != '0), W'(x - 1'b1)};
      endcase
    end else begin
      case (s)
        2'd0: return {1'b0, x & y};
        2'd1: return {1'b0, x | y};
        2'd2: return {1'b0, x ^ y};
        default: return {1'b0, ~x};
      endcase
    end
  endfunction

  task automatic check(input string rq, input logic [W:0] exp);
    checks++;
    if ({cout, res} !== exp) begin
      fails++;
      $display("FAIL %s: mode=%0b sel=%0d a=%h b=%h got cout=%0b res=%h expected cout=%0b res=%h",
               rq, mode, sel, a, b, cout, res, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic apply(input logic m, input logic [1:0] s,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    mode = m; sel = s; a = x; b = y;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; mode = 1'b0; sel = 2'd0;
    // Idle state with zero inputs: 0 + 0 (R1)
    apply(1'b0, 2'd0, '0, '0);
    check("R1", '0);

    // Table walk: every operation with hand-computed results
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][51], VEC[i][50:49], VEC[i][48:33], VEC[i][32:17]);
      check(tag(VEC[i][51], VEC[i][50:49]), VEC[i][16:0]);
    end

    // Random operands over all eight operations (R1..R8 via tag)
    for (int i = 0; i < 400; i++) begin
      logic m;
      logic [1:0] s;
      logic [W-1:0] x, y;
      m = 1'($urandom); s = 2'($urandom);
      x = W'($urandom); y = W'($urandom);
      apply(m, s, x, y);
      check(tag(m, s), model(m, s, x, y));
    end

    // R2 corner: equal operands give zero with no borrow
    apply(1'b0, 2'd1, 16'h7A7A, 16'h7A7A);
    check("R2", {1'b1, 16'h0000});
    // R3 and R4: B has no effect
    apply(1'b0, 2'd2, 16'h0010, 16'hFFFF);
    check("R3", {1'b0, 16'h0011});
    apply(1'b0, 2'd3, 16'h0001, 16'hFFFF);
    check("R4", {1'b1, 16'h0000});
    // R8: B has no effect on the complement
    apply(1'b1, 2'd3, 16'h00FF, 16'h0000);
    check("R8", {1'b0, 16'hFF00});
    apply(1'b1, 2'd3, 16'h00FF, 16'hFFFF);
    check("R8", {1'b0, 16'hFF00});
    // R9: logic mode with operands that would carry in every bit
    for (int s = 0; s < 4; s++) begin
      apply(1'b1, 2'(s), 16'hFFFF, 16'hFFFF);
      check("R9", model(1'b1, 2'(s), 16'hFFFF, 16'hFFFF));
    end

    // R10: inputs change between clock edges, outputs follow without an edge
    @(negedge clk);
    mode = 1'b0; sel = 2'd0; a = 16'h0F00; b = 16'h00F0;
    #0.5;
    check("R10", {1'b0, 16'h0FF0});
    a = 16'hFFFF; b = 16'h0001;
    #0.5;
    check("R10", {1'b1, 16'h0000});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule